// File: doc/BRIEF.md
# Rolling-Shutter Row Sequencer

This block paces the row-by-row readout of an image array in rolling order. Each row is addressed and receives an access strobe, and then goes through conversion. The readout of that row is launched while the next row is already being accessed and converted. Because every row keeps integrating until the sequencer addresses it again in the next frame, integration time can be stretched in two ways. One is a programmable pause between the end of one row's conversion and the next row's access. The other is a programmable pause after the last row's readout and before the next frame begins.

A frame is started by a rising edge on the external init input. After that, frames repeat back to back. While init is held high, every row that is addressed also receives a reset strobe, so it stays cleared. The cycle after init is seen low, a one-cycle pulse marks the start of integration. A row window and a mask of the two array halves (left and right) select which rows and which halves are strobed. A window request is checked when it is written and is applied from the next frame start.

Top module: `rs_row_seq`

## Requirements
- R1: After reset all strobes and pulses are low, `row_addr` is 0, and nothing starts until `seq_init` rises.
- R2: The first access strobe of a frame appears two rising edges after `seq_init` is first sampled high. Rows are then addressed one at a time, ascending from the window start to the window end, and `row_addr` holds each row through its whole slot.
- R3: Each row's access strobe lasts ACC_CYC cycles. It is followed by conversion for CONV_CYC cycles, and `conv_go` is a one-cycle pulse in the first conversion cycle, with no access strobe active at the same time.
- R4: In the first cycle after a row's conversion, `rd_go` pulses for one cycle with `rd_addr` set to that row. When the row gap is 0, this cycle is also the first access cycle of the next row.
- R5: Between one row's conversion and the next row's access there are exactly `row_gap` idle cycles. A value of 0 inserts none.
- R6: The last row of the window still gets its `rd_go`. A readout tail of RD_CYC cycles follows, then exactly `frame_gap` idle cycles, and then the next frame starts by itself at the window start.
- R7: `row_rst` equals `row_acc` whenever `seq_init` was high at the previous edge, and is 0 otherwise. `integ_go` pulses for one cycle in the cycle after `seq_init` is first sampled low.
- R8: `row_acc[0]` and `row_rst[0]` drive the left half and bit 1 drives the right half. Only the halves enabled in the current `half_sel` mask (bit 0 left, bit 1 right) are strobed.
- R9: A `win_load` request is accepted only when `win_lo <= win_hi <= ROWS-1` and `half_sel` is not 0. A rejected request is ignored and the previous window is kept. An accepted window takes effect at the next frame start. The window after reset covers all rows with both halves enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_init | input | 1 | Frame start (rising edge) and reset hold (high level) |
| win_load | input | 1 | One-cycle request to load a new window |
| win_lo | input | ROW_W | Requested first row |
| win_hi | input | ROW_W | Requested last row |
| half_sel | input | 2 | Requested half mask, bit 0 left, bit 1 right |
| row_gap | input | DLY_W | Idle cycles inserted between rows |
| frame_gap | input | DLY_W | Idle cycles inserted after each frame |
| row_addr | output | ROW_W | Address of the row being handled |
| row_acc | output | 2 | Access strobe per half |
| row_rst | output | 2 | Reset strobe per half |
| conv_go | output | 1 | Conversion start pulse |
| rd_go | output | 1 | Readout start pulse |
| rd_addr | output | ROW_W | Row whose readout is starting |
| integ_go | output | 1 | Integration start pulse |

## Verification
The bench builds the block with 16 rows, 8-bit delays and slot lengths of 2, 3 and 4 cycles. A whole frame therefore lasts only tens of cycles, and many random windows, gaps and half masks fit into one run. These small values bring several corners within reach: single-row windows, a window that ends on the top row, zero and non-zero gaps, and rejected windows, all compared cycle by cycle against a schedule computed in the bench.

// File: rtl/rs_seq_pkg.sv
package rs_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_CONV,
    ST_RGAP,
    ST_TAIL,
    ST_FGAP
  } rs_state_e;

  localparam int unsigned HALVES = 2;
endpackage

// File: rtl/rs_dwell_timer.sv
module rs_dwell_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/rs_win_shadow.sv
module rs_win_shadow #(
  parameter int unsigned ROWS  = 2048,
  parameter int unsigned ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] lo_in,
  input  logic [ROW_W-1:0] hi_in,
  input  logic [1:0]       half_in,
  output logic [ROW_W-1:0] lo_q,
  output logic [ROW_W-1:0] hi_q,
  output logic [1:0]       half_q
);
  localparam logic [ROW_W-1:0] TOP_ROW = ROW_W'(ROWS - 1);

  logic req_ok, upd_en;

  always_comb begin
    req_ok = (hi_in >= lo_in) && (hi_in <= TOP_ROW) && (half_in != 2'b00);
    upd_en = load && req_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= TOP_ROW;
      half_q <= 2'b11;
    end else if (upd_en) begin
      lo_q   <= lo_in;
      hi_q   <= hi_in;
      half_q <= half_in;
    end
  end
endmodule

// File: rtl/rs_row_seq.sv
module rs_row_seq
  import rs_seq_pkg::*;
#(
  parameter int unsigned ROWS     = 2048,
  parameter int unsigned DLY_W    = 16,
  parameter int unsigned ACC_CYC  = 4,
  parameter int unsigned CONV_CYC = 8,
  parameter int unsigned RD_CYC   = 10,
  localparam int unsigned ROW_W   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_init,
  input  logic             win_load,
  input  logic [ROW_W-1:0] win_lo,
  input  logic [ROW_W-1:0] win_hi,
  input  logic [1:0]       half_sel,
  input  logic [DLY_W-1:0] row_gap,
  input  logic [DLY_W-1:0] frame_gap,
  output logic [ROW_W-1:0] row_addr,
  output logic [1:0]       row_acc,
  output logic [1:0]       row_rst,
  output logic             conv_go,
  output logic             rd_go,
  output logic [ROW_W-1:0] rd_addr,
  output logic             integ_go
);
  localparam logic [DLY_W-1:0] ACC_LD  = DLY_W'(ACC_CYC - 1);
  localparam logic [DLY_W-1:0] CONV_LD = DLY_W'(CONV_CYC - 1);
  localparam logic [DLY_W-1:0] RD_LD   = DLY_W'(RD_CYC - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // init edge detection
  logic init_q, init_p, init_rise;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      init_q <= 1'b0;
      init_p <= 1'b0;
    end else begin
      init_q <= seq_init;
      init_p <= init_q;
    end
  end
  assign init_rise = init_q & ~init_p;
  assign integ_go  = init_p & ~init_q;

  // window shadow, checked on write
  logic [ROW_W-1:0] sh_lo, sh_hi;
  logic [1:0]       sh_half;

  rs_win_shadow #(.ROWS(ROWS), .ROW_W(ROW_W)) i_win (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (win_load),
    .lo_in   (win_lo),
    .hi_in   (win_hi),
    .half_in (half_sel),
    .lo_q    (sh_lo),
    .hi_q    (sh_hi),
    .half_q  (sh_half)
  );

  // slot timer
  logic             tmr_ld, tmr_zero;
  logic [DLY_W-1:0] tmr_val;

  rs_dwell_timer #(.W(DLY_W)) i_tmr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_ld),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  // sequencer state
  rs_state_e        st_q, st_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [ROW_W-1:0] act_hi_q;
  logic [1:0]       act_half_q;
  logic             conv_go_q, conv_go_d;
  logic             rd_go_q, rd_go_d;
  logic [ROW_W-1:0] rd_addr_q, rd_addr_d;
  logic             frame_go;

  always_comb begin
    st_d      = st_q;
    row_d     = row_q;
    tmr_ld    = 1'b0;
    tmr_val   = '0;
    conv_go_d = 1'b0;
    rd_go_d   = 1'b0;
    rd_addr_d = rd_addr_q;
    frame_go  = 1'b0;
    unique case (st_q)
      ST_IDLE: frame_go = init_rise;
      ST_ACC: if (tmr_zero) begin
        st_d      = ST_CONV;
        tmr_ld    = 1'b1;
        tmr_val   = CONV_LD;
        conv_go_d = 1'b1;
      end
      ST_CONV: if (tmr_zero) begin
        rd_go_d   = 1'b1;
        rd_addr_d = row_q;
        tmr_ld    = 1'b1;
        if (row_q == act_hi_q) begin
          st_d    = ST_TAIL;
          tmr_val = RD_LD;
        end else if (row_gap != '0) begin
          st_d    = ST_RGAP;
          tmr_val = row_gap - 1'b1;
        end else begin
          st_d    = ST_ACC;
          row_d   = row_q + 1'b1;
          tmr_val = ACC_LD;
        end
      end
      ST_RGAP: if (tmr_zero) begin
        st_d    = ST_ACC;
        row_d   = row_q + 1'b1;
        tmr_ld  = 1'b1;
        tmr_val = ACC_LD;
      end
      ST_TAIL: if (tmr_zero) begin
        if (frame_gap != '0) begin
          st_d    = ST_FGAP;
          tmr_ld  = 1'b1;
          tmr_val = frame_gap - 1'b1;
        end else begin
          frame_go = 1'b1;
        end
      end
      ST_FGAP: frame_go = tmr_zero;
      default: st_d = ST_IDLE;
    endcase
    if (frame_go) begin
      st_d    = ST_ACC;
      row_d   = sh_lo;
      tmr_ld  = 1'b1;
      tmr_val = ACC_LD;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q      <= ST_IDLE;
      row_q     <= '0;
      conv_go_q <= 1'b0;
      rd_go_q   <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      st_q      <= st_d;
      row_q     <= row_d;
      conv_go_q <= conv_go_d;
      rd_go_q   <= rd_go_d;
      rd_addr_q <= rd_addr_d;
    end
  end

  // active window, captured at each frame start
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      act_hi_q   <= '0;
      act_half_q <= 2'b00;
    end else if (frame_go) begin
      act_hi_q   <= sh_hi;
      act_half_q <= sh_half;
    end
  end

  // per-half strobe gating
  logic in_acc;
  assign in_acc = (st_q == ST_ACC);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign row_acc[h] = in_acc & act_half_q[h];
    assign row_rst[h] = in_acc & act_half_q[h] & init_q;
  end

  assign row_addr = row_q;
  assign conv_go  = conv_go_q;
  assign rd_go    = rd_go_q;
  assign rd_addr  = rd_addr_q;
endmodule

// File: rtl/rs_row_seq_chk.sv
module rs_row_seq_chk #(
  parameter int unsigned ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ROW_W-1:0] row_addr,
  input logic [1:0]       row_acc,
  input logic [1:0]       row_rst,
  input logic             conv_go,
  input logic             rd_go,
  input logic [ROW_W-1:0] rd_addr,
  input logic             integ_go
);
  // R3
  conv_apart_from_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |-> (row_acc == 2'b00));

  // R3
  conv_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |=> !conv_go);

  // R4
  rd_row_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> (rd_addr == $past(row_addr)));

  // R2
  addr_held_in_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_acc != 2'b00) && ($past(row_acc) != 2'b00)) |-> $stable(row_addr));

  // R7
  rst_only_with_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_rst & ~row_acc) == 2'b00));

  // R7
  integ_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    integ_go |=> !integ_go);
endmodule

bind rs_row_seq rs_row_seq_chk #(.ROW_W(ROW_W)) i_rs_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .row_addr (row_addr),
  .row_acc  (row_acc),
  .row_rst  (row_rst),
  .conv_go  (conv_go),
  .rd_go    (rd_go),
  .rd_addr  (rd_addr),
  .integ_go (integ_go)
);

// File: tb/test_rs_row_seq.sv
module test_rs_row_seq;
  localparam int ROWS = 16;
  localparam int RW   = 4;
  localparam int DW   = 8;
  localparam int ACC  = 2;
  localparam int CONV = 3;
  localparam int RD   = 4;

  logic          clk = 1'b0;
  logic          rst_n, seq_init, win_load;
  logic [RW-1:0] win_lo, win_hi, row_addr, rd_addr;
  logic [1:0]    half_sel, row_acc, row_rst;
  logic [DW-1:0] row_gap, frame_gap;
  logic          conv_go, rd_go, integ_go;

  always #4 clk = ~clk;

  rs_row_seq #(.ROWS(ROWS), .DLY_W(DW), .ACC_CYC(ACC), .CONV_CYC(CONV), .RD_CYC(RD)) i_rs_row_seq (
    .clk(clk), .rst_n(rst_n), .seq_init(seq_init), .win_load(win_load),
    .win_lo(win_lo), .win_hi(win_hi), .half_sel(half_sel),
    .row_gap(row_gap), .frame_gap(frame_gap), .row_addr(row_addr),
    .row_acc(row_acc), .row_rst(row_rst), .conv_go(conv_go), .rd_go(rd_go),
    .rd_addr(rd_addr), .integ_go(integ_go)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cw_lo, cw_hi, cw_half;
  bit ld_req;
  int ld_lo, ld_hi, ld_half;
  bit init_now, fall_exp;
  int drop_row;

  task automatic cmp(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    win_load = 1'b0;
  endtask

  function automatic bit win_ok(int lo, int hi, int hf);
    return (lo <= hi) && (hi <= ROWS - 1) && (hf != 0);
  endfunction

  // one sampled cycle against the expected schedule
  task automatic chk(int e_acc, int e_row, int e_conv, int e_rd, int e_rda);
    cmp("R8 row_acc", int'(row_acc), e_acc);
    cmp("R2 row_addr", int'(row_addr), e_row);
    cmp("R3 conv_go", int'(conv_go), e_conv);
    cmp("R4 rd_go", int'(rd_go), e_rd);
    if (e_rd != 0) cmp("R4 rd_addr", int'(rd_addr), e_rda);
    cmp("R7 row_rst", int'(row_rst), init_now ? e_acc : 0);
    cmp("R7 integ_go", int'(integ_go), int'(fall_exp));
    fall_exp = 1'b0;
  endtask

  // starts at the first access cycle of a frame, ends at the next one
  task automatic run_frame(int rgap, int fgap);
    int lo = cw_lo;
    int hi = cw_hi;
    int hf = cw_half;
    bit pend = 1'b0;
    int pend_a = 0;
    row_gap   = DW'(rgap);
    frame_gap = DW'(fgap);
    for (int r = lo; r <= hi; r++) begin
      for (int i = 0; i < ACC; i++) begin
        chk(hf, r, 0, (i == 0 && pend) ? 1 : 0, pend_a);  // R2 R4 R5 R8
        if (i == 0) begin
          pend = 1'b0;
          if (r == lo && ld_req) begin
            win_load = 1'b1;
            win_lo   = RW'(ld_lo);
            win_hi   = RW'(ld_hi);
            half_sel = 2'(ld_half);
          end
          if (r == drop_row && init_now) begin
            seq_init = 1'b0;
            init_now = 1'b0;
            fall_exp = 1'b1;
          end
        end
        step();
      end
      for (int i = 0; i < CONV; i++) begin
        chk(0, r, (i == 0) ? 1 : 0, 0, 0);  // R3
        step();
      end
      if (r == hi) begin
        for (int i = 0; i < RD; i++) begin
          chk(0, r, 0, (i == 0) ? 1 : 0, r);  // R6
          step();
        end
        for (int i = 0; i < fgap; i++) begin
          chk(0, r, 0, 0, 0);  // R6
          step();
        end
      end else if (rgap > 0) begin
        for (int i = 0; i < rgap; i++) begin
          chk(0, r, 0, (i == 0) ? 1 : 0, r);  // R5
          step();
        end
      end else begin
        pend   = 1'b1;
        pend_a = r;
      end
    end
    if (ld_req && win_ok(ld_lo, ld_hi, ld_half)) begin  // R9
      cw_lo   = ld_lo;
      cw_hi   = ld_hi;
      cw_half = ld_half;
    end
    ld_req   = 1'b0;
    drop_row = -1;
  endtask

  task automatic req_load(int lo, int hi, int hf);
    ld_req  = 1'b1;
    ld_lo   = lo;
    ld_hi   = hi;
    ld_half = hf;
  endtask

  initial begin
    int unsigned seed_v;
    seed_v    = $urandom(32'd4711);
    rst_n     = 1'b0;
    seq_init  = 1'b0;
    win_load  = 1'b0;
    win_lo    = '0;
    win_hi    = '0;
    half_sel  = 2'b11;
    row_gap   = '0;
    frame_gap = '0;
    init_now  = 1'b0;
    fall_exp  = 1'b0;
    ld_req    = 1'b0;
    drop_row  = -1;
    cw_lo     = 0;
    cw_hi     = ROWS - 1;
    cw_half   = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet after reset with no init
    for (int i = 0; i < 6; i++) begin
      step();
      chk(0, 0, 0, 0, 0);
    end
    // R2: start latency
    seq_init = 1'b1;
    init_now = 1'b1;
    step();
    chk(0, 0, 0, 0, 0);  // R1 still idle one edge after
    step();
    // frame 1: full window, both halves, init dropped at row 2 (R7)
    drop_row = 2;
    req_load(3, 5, 1);  // valid, left only (R8 R9)
    run_frame(0, 0);
    // frame 2: rejected load with hi < lo (R9)
    req_load(9, 4, 3);
    run_frame(2, 3);
    // frame 3: rejected load with empty half mask (R9)
    req_load(0, 1, 0);
    run_frame(1, 0);
    // frame 4: single top row on right half
    req_load(15, 15, 2);
    run_frame(0, 2);
    run_frame(3, 1);  // single-row window, R6 tail
    // random frames
    for (int f = 0; f < 30; f++) begin
      int a = int'($urandom_range(0, ROWS - 1));
      int b = int'($urandom_range(0, ROWS - 1));
      int h = int'($urandom_range(0, 3));
      if (($urandom_range(0, 3) != 0) && a > b) begin
        int t = a;
        a = b;
        b = t;
      end
      req_load(a, b, h);
      run_frame(int'($urandom_range(0, 3)), int'($urandom_range(0, 4)));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule